// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 32K words of 8 bits. The host issues one word per request through a valid/ready handshake, with an address, a write flag and write data. The block then plays out the chip-select, write-enable and output-enable strobes for that word so that each minimum window of the memory is met. These windows are cycle time, address and data setup, pulse width, hold, access time and bus release. When a read completes, the byte is handed back with a one-cycle valid flag.

Every timing limit is a nanosecond parameter. At elaboration the block turns each limit into a whole number of clocks, rounding up against the clock-period parameter, so any nonzero limit costs at least one clock. The memory data bus is split into an outgoing byte, an incoming byte and a drive enable. The block drives the bus only while the memory's output enable is inactive. A read is not finished until the memory has had its full release time, so the next access can drive the bus safely.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and while reset is held, the strobes `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write drives `mem_cs_n` and `mem_we_n` low together in the cycle after acceptance. They stay low for WLOW clocks, where WLOW is the largest of the rounded-up write pulse, data setup, select-to-end and address-to-end limits (12 clocks at 5 ns with the default limits). `mem_oe_n` stays 1 for the whole write. The address and write data stay stable for the whole write.
- R3: After a write's strobes rise, the address and data stay driven for WREC clocks. WREC is the largest of 1, the rounded-up recovery and hold limits, and the rounded-up write cycle minus WLOW (2 clocks by default). `req_ready` is therefore low for WLOW+WREC clocks (14), and `mem_dq_oe` is 1 for exactly those clocks.
- R4: A read drives `mem_cs_n` and `mem_oe_n` low in the cycle after acceptance. They stay low for RLOW clocks, the largest of the rounded-up address-access, select-access and output-enable-access limits (14 by default). `mem_we_n` stays 1 and `mem_dq_oe` stays 0 throughout the read.
- R5: At the clock edge that ends a read's strobe window, the block latches `mem_dq_in` into `rsp_rdata`. `rsp_valid` goes high for exactly one clock, in the same cycle that the strobes return high.
- R6: After a read's strobes rise, `req_ready` stays low for RFLT more clocks. RFLT is the largest of 1, the rounded-up output-release limits, and the rounded-up read cycle minus RLOW (5 by default). `req_ready` is therefore low for RLOW+RFLT clocks (19) per read.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: A request is accepted only on a clock edge where `req_ready` is 1. A request held while the block is busy has no effect on the strobes, address or data. If it is withdrawn before `req_ready` rises, no access follows.
- R9: `mem_we_n` is never 0 unless `mem_cs_n` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle; request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle flag: read data present |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Byte the block drives onto the memory bus |
| mem_dq_in | input | DATA_W | Byte seen on the memory bus |
| mem_dq_oe | output | 1 | Block drives the memory bus |

## Verification
Every strobe change lands one clock after the edge that accepts the request. Each window then closes a fixed number of clocks later: 12 and 2 clocks for a write, 14 and 5 clocks for a read at the default limits. `rsp_valid` appears in sample 14 counted from acceptance. The bench drives inputs and samples outputs on falling edges. For each access it counts the samples that show each strobe low, the bus driven and ready low, and it records the sample index where the response flag appears. The memory model returns a byte derived from the address only while select and output enable are both low, so an early or late capture yields a wrong byte or a wrong index.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WPULSE,
      ST_WREC,
      ST_RACC,
      ST_RFLT
   } seq_state_t;

   // ceiling of a nanosecond limit in clocks; nonzero limits give >= 1
   function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                             input int unsigned clk_ns);
      if (t_ns == 0) return 0;
      return (t_ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a,
                                        input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // a - b clamped at zero
   function automatic int unsigned usub0(input int unsigned a,
                                         input int unsigned b);
      return (a > b) ? (a - b) : 0;
   endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int WLOW  = 12,
   parameter int WREC  = 2,
   parameter int RLOW  = 14,
   parameter int RFLT  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             cnt_done,
   output logic             cnt_load,
   output logic [CNT_W-1:0] cnt_val,
   output logic             accept,
   output logic             capture,
   output logic             ready,
   output logic             cs_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe
);

   seq_state_t state_q, state_d;

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               cnt_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WPULSE;
                  cnt_val = CNT_W'(WLOW - 1);
               end else begin
                  state_d = ST_RACC;
                  cnt_val = CNT_W'(RLOW - 1);
               end
            end
         end
         ST_WPULSE: begin
            if (cnt_done) begin
               state_d  = ST_WREC;
               cnt_load = 1'b1;
               cnt_val  = CNT_W'(WREC - 1);
            end
         end
         ST_WREC: begin
            if (cnt_done) state_d = ST_IDLE;
         end
         ST_RACC: begin
            if (cnt_done) begin
               state_d  = ST_RFLT;
               cnt_load = 1'b1;
               cnt_val  = CNT_W'(RFLT - 1);
            end
         end
         ST_RFLT: begin
            if (cnt_done) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign capture = (state_q == ST_RACC) && cnt_done;
   assign ready   = (state_q == ST_IDLE);

   // strobes are registered images of the next state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cs_n    <= 1'b1;
         we_n    <= 1'b1;
         oe_n    <= 1'b1;
         dq_oe   <= 1'b0;
      end else begin
         state_q <= state_d;
         cs_n    <= !((state_d == ST_WPULSE) || (state_d == ST_RACC));
         we_n    <= (state_d != ST_WPULSE);
         oe_n    <= (state_d != ST_RACC);
         dq_oe   <= (state_d == ST_WPULSE) || (state_d == ST_WREC);
      end
   end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_in;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int DATA_W   = 8,
   parameter int CLK_NS   = 5,
   parameter int T_RC_NS  = 70,
   parameter int T_AA_NS  = 70,
   parameter int T_CO_NS  = 70,
   parameter int T_OE_NS  = 35,
   parameter int T_HZ_NS  = 25,
   parameter int T_OHZ_NS = 25,
   parameter int T_WC_NS  = 70,
   parameter int T_CW_NS  = 60,
   parameter int T_AW_NS  = 60,
   parameter int T_WP_NS  = 50,
   parameter int T_DW_NS  = 30,
   parameter int T_WR_NS  = 0,
   parameter int T_DH_NS  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int unsigned CK = CLK_NS;

   localparam int WLOW = umax(1, umax(umax(ns_to_cyc(T_WP_NS, CK), ns_to_cyc(T_DW_NS, CK)),
                                      umax(ns_to_cyc(T_CW_NS, CK), ns_to_cyc(T_AW_NS, CK))));
   localparam int WREC = umax(1, umax(umax(ns_to_cyc(T_WR_NS, CK), ns_to_cyc(T_DH_NS, CK)),
                                      usub0(ns_to_cyc(T_WC_NS, CK), WLOW)));
   localparam int RLOW = umax(1, umax(ns_to_cyc(T_AA_NS, CK),
                                      umax(ns_to_cyc(T_CO_NS, CK), ns_to_cyc(T_OE_NS, CK))));
   localparam int RFLT = umax(1, umax(umax(ns_to_cyc(T_OHZ_NS, CK), ns_to_cyc(T_HZ_NS, CK)),
                                      usub0(ns_to_cyc(T_RC_NS, CK), RLOW)));
   localparam int MAXC  = umax(umax(WLOW, WREC), umax(RLOW, RFLT));
   localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W and DATA_W must be at least 1");
   end

   logic             cnt_load;
   logic [CNT_W-1:0] cnt_val;
   logic             cnt_done;
   logic             accept;
   logic             capture;

   sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .done     (cnt_done)
   );

   sram_seq_fsm #(
      .CNT_W (CNT_W),
      .WLOW  (WLOW),
      .WREC  (WREC),
      .RLOW  (RLOW),
      .RFLT  (RFLT)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .cnt_done  (cnt_done),
      .cnt_load  (cnt_load),
      .cnt_val   (cnt_val),
      .accept    (accept),
      .capture   (capture),
      .ready     (req_ready),
      .cs_n      (mem_cs_n),
      .we_n      (mem_we_n),
      .oe_n      (mem_oe_n),
      .dq_oe     (mem_dq_oe)
   );

   sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata)
   );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 8,
   parameter int CLK_NS  = 5,
   parameter int T_CW_NS = 60,
   parameter int T_AW_NS = 60,
   parameter int T_WP_NS = 50,
   parameter int T_DW_NS = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   localparam int unsigned CK = CLK_NS;
   localparam int WMIN = umax(1, umax(umax(ns_to_cyc(T_WP_NS, CK), ns_to_cyc(T_DW_NS, CK)),
                                      umax(ns_to_cyc(T_CW_NS, CK), ns_to_cyc(T_AW_NS, CK))));

   logic [15:0] we_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_low_cnt <= '0;
      else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
      else                we_low_cnt <= '0;
   end

   a_r1_ready_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   a_r2_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

   a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

   a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_cnt == 16'(WMIN)));

   a_r5_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r5_rsp_at_oe_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(mem_oe_n));

   a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r8_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> $past(req_valid));

   a_r9_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_cs_n);

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .CLK_NS  (CLK_NS),
   .T_CW_NS (T_CW_NS),
   .T_AW_NS (T_AW_NS),
   .T_WP_NS (T_WP_NS),
   .T_DW_NS (T_DW_NS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_cs_n   (mem_cs_n),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;

   // expected windows at 5 ns: ceil(50,30,60,60 / 5) -> 12; ceil(70/5)-12 -> 2
   // read: ceil(70,70,35 / 5) -> 14; ceil(25/5)=5 vs 14-14=0 -> 5
   localparam int EXP_WLOW = 12;
   localparam int EXP_WREC = 2;
   localparam int EXP_RLOW = 14;
   localparam int EXP_RFLT = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [14:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out, mem_dq_in;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] pat(input logic [14:0] a);
      return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
   endfunction

   // memory model: drives a byte only while selected and output-enabled
   always_comb mem_dq_in = (!mem_cs_n && !mem_oe_n) ? pat(mem_addr) : 8'h00;

   sram_async_ctrl u0 (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n),
      .mem_oe_n (mem_oe_n), .mem_dq_out (mem_dq_out), .mem_dq_in (mem_dq_in),
      .mem_dq_oe (mem_dq_oe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      check(mem_cs_n && mem_we_n && mem_oe_n, req, {mem_cs_n, mem_we_n, mem_oe_n}, 7);
      check(!mem_dq_oe && !rsp_valid, req, {mem_dq_oe, rsp_valid}, 0);
      check(req_ready, req, req_ready, 1);
   endtask

   // one access; samples on falling edges, sample 0 follows the accepting edge
   task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
      int cs_lo = 0, we_lo = 0, oe_lo = 0, drv = 0, busy = 0, rsp_n = 0, rsp_k = -1;
      int cont = 0;
      logic [14:0] seen_a = '0;
      logic [7:0]  seen_d = '0, got = '0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready && busy < 60) begin
         if (!mem_cs_n) begin cs_lo++; seen_a = mem_addr; end
         if (!mem_we_n) begin we_lo++; seen_d = mem_dq_out; end
         if (!mem_oe_n) oe_lo++;
         if (mem_dq_oe) drv++;
         if (mem_dq_oe && !mem_oe_n) cont++;
         if (rsp_valid) begin rsp_n++; rsp_k = busy; got = rsp_rdata; end
         busy++;
         @(negedge clk);
      end
      if (rsp_valid) rsp_n++;
      check(cont == 0, "R7 bus contention samples", cont, 0);
      if (wr) begin
         check(we_lo == EXP_WLOW && cs_lo == EXP_WLOW, "R2 write strobe width", we_lo, EXP_WLOW);
         check(oe_lo == 0, "R2 oe during write", oe_lo, 0);
         check(seen_a == a, "R2 write address", int'(seen_a), int'(a));
         check(seen_d == d, "R2 write data", int'(seen_d), int'(d));
         check(busy == EXP_WLOW + EXP_WREC, "R3 write busy", busy, EXP_WLOW + EXP_WREC);
         check(drv == EXP_WLOW + EXP_WREC, "R3 data drive span", drv, EXP_WLOW + EXP_WREC);
         check(rsp_n == 0, "R5 no response on write", rsp_n, 0);
      end else begin
         check(oe_lo == EXP_RLOW && cs_lo == EXP_RLOW, "R4 read strobe width", oe_lo, EXP_RLOW);
         check(we_lo == 0 && drv == 0, "R4 no write or drive in read", we_lo + drv, 0);
         check(seen_a == a, "R4 read address", int'(seen_a), int'(a));
         check(rsp_n == 1, "R5 response count", rsp_n, 1);
         check(rsp_k == EXP_RLOW, "R5 response cycle", rsp_k, EXP_RLOW);
         check(got == pat(a), "R5 read data", int'(got), int'(pat(a)));
         check(busy == EXP_RLOW + EXP_RFLT, "R6 read busy", busy, EXP_RLOW + EXP_RFLT);
      end
   endtask

   // {write, addr[14:0], data[7:0]}
   localparam logic [23:0] VEC [6] = '{
      {1'b1, 15'h0000, 8'hA5},
      {1'b0, 15'h7FFF, 8'h00},
      {1'b1, 15'h7FFF, 8'hFF},
      {1'b0, 15'h1234, 8'h00},
      {1'b0, 15'h0000, 8'h00},
      {1'b1, 15'h2AAA, 8'h00}
   };

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset");

      foreach (VEC[i]) do_op(VEC[i][23], VEC[i][22:8], VEC[i][7:0]);

      // R8: request held while busy is ignored, then withdrawn
      begin
         int extra = 0;
         logic [14:0] seen = '0;
         @(negedge clk);
         req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0155; req_wdata = 8'h5A;
         @(negedge clk);
         req_addr = 15'h6E6E; req_wdata = 8'hC3; req_write = 1'b0;
         for (int k = 0; k < EXP_WLOW + EXP_WREC; k++) begin
            if (!mem_cs_n) seen = mem_addr;
            if (!mem_oe_n) extra++;
            if (k == EXP_WLOW + EXP_WREC - 1) req_valid = 1'b0;
            @(negedge clk);
         end
         check(seen == 15'h0155, "R8 busy request ignored", int'(seen), 'h155);
         check(extra == 0, "R8 no read from busy request", extra, 0);
         for (int k = 0; k < 25; k++) begin
            if (!mem_cs_n) extra++;
            @(negedge clk);
         end
         check(extra == 0 && req_ready, "R8 withdrawn request starts nothing", extra, 0);
      end

      // R1: reset in the middle of a write returns to idle
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0042; req_wdata = 8'h11;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(!mem_we_n, "R2 write in progress before reset", mem_we_n, 0);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R1 reset mid write");
      rst_n = 1'b1;
      @(negedge clk);
      do_op(1'b0, 15'h0042, 8'h00);

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule